// File: doc/BRIEF.md
# Warp Instruction Issue Steering

This block takes one decoded warp instruction per cycle and sends it into one of three pipeline register sets: the simple-ALU set, the special-function set or the memory set. Each set has a parameterized number of slots and reports one "free" bit per slot. The block writes the instruction into the lowest-indexed free slot of the set it picks. The write is a one-hot strobe per slot, and the instruction payload is shared by all sets. The choice depends on the opcode class. Memory-class work can only go to the memory set. Special-function work can only go to the special-function set. Generic ALU work goes to the simple-ALU set when it can, and falls back to the special-function set otherwise.

The instruction input is a valid/ready stream. `in_ready` is high when an eligible destination has a free slot for the presented opcode class. It depends only on the opcode class and the free bits, never on `in_valid`. An instruction issues in the cycle where `in_valid && in_ready` holds. When no eligible slot is free, the producer must hold the instruction, unchanged, until a later cycle where `in_ready` rises. Destination free bits are plain status inputs. The per-slot write strobes act as single-cycle pulses, and the sets have no way to push back against them.

Two side effects apply to the issuing warp. A barrier instruction raises a one-cycle arrival event that carries the warp ID. A memory-barrier instruction sets a per-warp flag, which stays set until a matching clear bit arrives. For every issue the block also produces the warp's next PC, which is the instruction PC plus the instruction size.

Top module: `issue_steer`

## Requirements
- R1: Opcode classes 2 (load), 3 (store) and 4 (memory barrier) are written only into the memory set, and only when at least one memory slot is free. In every other case `in_ready` is low.
- R2: Opcode classes 0, 5, 6 and 7 (generic ALU, where 5 is the barrier) go to the simple-ALU set whenever any simple-ALU slot is free, even when a special-function slot is also free.
- R3: A generic ALU instruction goes to the special-function set only when every simple-ALU slot is full and a special-function slot is free. If both sets are full, it is not accepted.
- R4: Opcode class 1 (special function) is written only into the special-function set and never into the simple-ALU set. If no special-function slot is free, it is not accepted.
- R5: On issue, exactly one write strobe is high across all three sets. That strobe is the lowest-indexed free slot of the chosen set. `out_warp`, `out_mask` and `out_op` carry the input instruction.
- R6: `issued` equals `in_valid && in_ready` in the same cycle. Without an issue, no write strobe is high and no side event fires.
- R7: When a barrier (class 5) issues, `bar_arrive` is high in that same cycle and `bar_warp` equals the warp ID. For any other class it stays low.
- R8: When a memory barrier issues, bit `in_warp` of `membar_flags` is 1 from the next cycle on. It stays 1 until `membar_clr` has that bit set. A set and a clear of the same warp in the same cycle leave the flag at 1. A memory barrier that does not issue changes no flag.
- R9: `next_pc` equals `in_pc + in_size`, taken modulo 2^PC_W, and `next_pc_vld` equals `issued`.
- R10: Reset clears all memory-barrier flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented |
| in_ready | output | 1 | An eligible destination slot is free |
| in_op | input | 3 | Opcode class (0 ALU, 1 SFU, 2 load, 3 store, 4 membar, 5 barrier, 6/7 ALU) |
| in_warp | input | WARP_W | Warp ID |
| in_mask | input | LANES | Active-thread mask |
| in_pc | input | PC_W | Instruction PC |
| in_size | input | SIZE_W | Instruction size |
| sp_free | input | SP_SLOTS | Free bit per simple-ALU slot |
| sfu_free | input | SFU_SLOTS | Free bit per special-function slot |
| mem_free | input | MEM_SLOTS | Free bit per memory slot |
| sp_wr | output | SP_SLOTS | One-hot write strobe into the simple-ALU set |
| sfu_wr | output | SFU_SLOTS | One-hot write strobe into the special-function set |
| mem_wr | output | MEM_SLOTS | One-hot write strobe into the memory set |
| out_warp | output | WARP_W | Warp ID written with the strobe |
| out_mask | output | LANES | Active mask written with the strobe |
| out_op | output | 3 | Opcode class written with the strobe |
| issued | output | 1 | An instruction issued this cycle |
| bar_arrive | output | 1 | Barrier arrival event |
| bar_warp | output | WARP_W | Warp ID of the barrier arrival |
| membar_clr | input | NUM_WARPS | Per-warp memory-barrier clear |
| membar_flags | output | NUM_WARPS | Per-warp memory-barrier pending flags |
| next_pc | output | PC_W | PC following the issued instruction |
| next_pc_vld | output | 1 | `next_pc` is valid |

## Verification
A wrong class decode or a wrong set preference shows up in the same cycle as a strobe on the wrong set, or as `in_ready` at the wrong level for a given pattern of free bits. A bad slot picker shows up at once as a strobe on an occupied or higher-indexed slot, or as more than one strobe high. Faults in the flag register only show one cycle after the memory-barrier issue or the clear. For that reason `membar_flags` is checked at the following cycle, and so are the cases of a held memory barrier and of a set and clear in the same cycle.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [2:0] {
    OPC_ALU     = 3'd0,
    OPC_SFU     = 3'd1,
    OPC_LOAD    = 3'd2,
    OPC_STORE   = 3'd3,
    OPC_MEMBAR  = 3'd4,
    OPC_BARRIER = 3'd5,
    OPC_ALU_B   = 3'd6,
    OPC_ALU_C   = 3'd7
  } op_class_e;

  function automatic logic is_mem_class(input op_class_e op);
    return (op == OPC_LOAD) || (op == OPC_STORE) || (op == OPC_MEMBAR);
  endfunction
endpackage

// File: rtl/slot_pick.sv
module slot_pick #(
  parameter int N = 1
) (
  input  logic [N-1:0] free,
  output logic [N-1:0] pick,
  output logic         any
);
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end
  assign any = |free;
endmodule

// File: rtl/steer_decide.sv
module steer_decide
  import steer_pkg::*;
(
  input  logic [2:0] op,
  input  logic       sp_any,
  input  logic       sfu_any,
  input  logic       mem_any,
  output logic       to_sp,
  output logic       to_sfu,
  output logic       to_mem,
  output logic       is_bar,
  output logic       is_membar
);
  op_class_e cls;
  logic      mem_cls, sfu_cls;

  always_comb begin
    cls     = op_class_e'(op);
    mem_cls = is_mem_class(cls);
    sfu_cls = (cls == OPC_SFU);
    to_mem  = mem_cls && mem_any;
    to_sp   = !mem_cls && !sfu_cls && sp_any;
    to_sfu  = !mem_cls && sfu_any && (sfu_cls || !sp_any);
    is_bar    = (cls == OPC_BARRIER);
    is_membar = (cls == OPC_MEMBAR);
  end
endmodule

// File: rtl/membar_flags.sv
module membar_flags #(
  parameter int NUM_WARPS = 8,
  localparam int WARP_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [WARP_W-1:0]    set_warp,
  input  logic [NUM_WARPS-1:0] clr,
  output logic [NUM_WARPS-1:0] flags
);
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic hit;
    assign hit = set_en && (set_warp == WARP_W'(w));
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[w] <= 1'b0;
      else if (hit)    flags[w] <= 1'b1;
      else if (clr[w]) flags[w] <= 1'b0;
    end
  end
endmodule

// File: rtl/issue_steer.sv
module issue_steer #(
  parameter int NUM_WARPS = 8,
  parameter int LANES     = 32,
  parameter int PC_W      = 32,
  parameter int SIZE_W    = 4,
  parameter int SP_SLOTS  = 1,
  parameter int SFU_SLOTS = 1,
  parameter int MEM_SLOTS = 1,
  localparam int WARP_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2:0]           in_op,
  input  logic [WARP_W-1:0]    in_warp,
  input  logic [LANES-1:0]     in_mask,
  input  logic [PC_W-1:0]      in_pc,
  input  logic [SIZE_W-1:0]    in_size,
  input  logic [SP_SLOTS-1:0]  sp_free,
  input  logic [SFU_SLOTS-1:0] sfu_free,
  input  logic [MEM_SLOTS-1:0] mem_free,
  output logic [SP_SLOTS-1:0]  sp_wr,
  output logic [SFU_SLOTS-1:0] sfu_wr,
  output logic [MEM_SLOTS-1:0] mem_wr,
  output logic [WARP_W-1:0]    out_warp,
  output logic [LANES-1:0]     out_mask,
  output logic [2:0]           out_op,
  output logic                 issued,
  output logic                 bar_arrive,
  output logic [WARP_W-1:0]    bar_warp,
  input  logic [NUM_WARPS-1:0] membar_clr,
  output logic [NUM_WARPS-1:0] membar_flags,
  output logic [PC_W-1:0]      next_pc,
  output logic                 next_pc_vld
);
  logic [SP_SLOTS-1:0]  sp_pick;
  logic [SFU_SLOTS-1:0] sfu_pick;
  logic [MEM_SLOTS-1:0] mem_pick;
  logic sp_any, sfu_any, mem_any;
  logic to_sp, to_sfu, to_mem, is_bar, is_membar;

  slot_pick #(.N(SP_SLOTS))  u_sp_pick  (.free(sp_free),  .pick(sp_pick),  .any(sp_any));
  slot_pick #(.N(SFU_SLOTS)) u_sfu_pick (.free(sfu_free), .pick(sfu_pick), .any(sfu_any));
  slot_pick #(.N(MEM_SLOTS)) u_mem_pick (.free(mem_free), .pick(mem_pick), .any(mem_any));

  steer_decide u_decide (
    .op(in_op), .sp_any(sp_any), .sfu_any(sfu_any), .mem_any(mem_any),
    .to_sp(to_sp), .to_sfu(to_sfu), .to_mem(to_mem),
    .is_bar(is_bar), .is_membar(is_membar)
  );

  assign in_ready = to_sp || to_sfu || to_mem;
  assign issued   = in_valid && in_ready;

  assign sp_wr  = {SP_SLOTS{issued && to_sp}}   & sp_pick;
  assign sfu_wr = {SFU_SLOTS{issued && to_sfu}} & sfu_pick;
  assign mem_wr = {MEM_SLOTS{issued && to_mem}} & mem_pick;

  assign out_warp = in_warp;
  assign out_mask = in_mask;
  assign out_op   = in_op;

  assign bar_arrive = issued && is_bar;
  assign bar_warp   = in_warp;

  membar_flags #(.NUM_WARPS(NUM_WARPS)) u_membar (
    .clk(clk), .rst_n(rst_n),
    .set_en(issued && is_membar), .set_warp(in_warp),
    .clr(membar_clr), .flags(membar_flags)
  );

  assign next_pc     = in_pc + PC_W'(in_size);
  assign next_pc_vld = issued;
endmodule

// File: rtl/issue_steer_chk.sv
module issue_steer_chk #(
  parameter int NUM_WARPS = 8,
  parameter int SP_SLOTS  = 1,
  parameter int SFU_SLOTS = 1,
  parameter int MEM_SLOTS = 1,
  localparam int WARP_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [2:0]           in_op,
  input logic [WARP_W-1:0]    in_warp,
  input logic [SP_SLOTS-1:0]  sp_free,
  input logic [SFU_SLOTS-1:0] sfu_free,
  input logic [MEM_SLOTS-1:0] mem_free,
  input logic [SP_SLOTS-1:0]  sp_wr,
  input logic [SFU_SLOTS-1:0] sfu_wr,
  input logic [MEM_SLOTS-1:0] mem_wr,
  input logic                 issued,
  input logic                 bar_arrive,
  input logic [NUM_WARPS-1:0] membar_flags
);
  logic mem_cls;
  assign mem_cls = (in_op == 3'd2) || (in_op == 3'd3) || (in_op == 3'd4);

  AST_MEM_ONLY_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && mem_cls) |-> ((|mem_wr) && !(|sp_wr) && !(|sfu_wr))); // R1
  AST_ALU_PREFERS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && !mem_cls && in_op != 3'd1 && (|sp_free)) |-> (|sp_wr)); // R2
  AST_SFU_NEVER_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && in_op == 3'd1) |-> !(|sp_wr)); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sp_wr, sfu_wr, mem_wr})); // R5
  AST_STROBE_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ((sp_wr & ~sp_free) == '0) && ((sfu_wr & ~sfu_free) == '0) && ((mem_wr & ~mem_free) == '0)); // R5
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |-> ({sp_wr, sfu_wr, mem_wr} == '0 && !bar_arrive)); // R6
  AST_MEMBAR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && in_op == 3'd4) |=> membar_flags[$past(in_warp)]); // R8
endmodule

bind issue_steer issue_steer_chk #(
  .NUM_WARPS(NUM_WARPS), .SP_SLOTS(SP_SLOTS), .SFU_SLOTS(SFU_SLOTS), .MEM_SLOTS(MEM_SLOTS)
) chk_i (.*);

// File: tb/issue_steer_tb_top.sv
`timescale 1ns/1ps
module issue_steer_tb_top;
  localparam int NW = 8, LN = 32, PW = 32, SW = 4, NSP = 2, NSFU = 1, NMEM = 3;
  localparam int WW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid, in_ready;
  logic [2:0] in_op, out_op;
  logic [WW-1:0] in_warp, out_warp, bar_warp;
  logic [LN-1:0] in_mask, out_mask;
  logic [PW-1:0] in_pc, next_pc;
  logic [SW-1:0] in_size;
  logic [NSP-1:0] sp_free, sp_wr;
  logic [NSFU-1:0] sfu_free, sfu_wr;
  logic [NMEM-1:0] mem_free, mem_wr;
  logic issued, bar_arrive, next_pc_vld;
  logic [NW-1:0] membar_clr, membar_flags;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  issue_steer #(.NUM_WARPS(NW), .LANES(LN), .PC_W(PW), .SIZE_W(SW),
    .SP_SLOTS(NSP), .SFU_SLOTS(NSFU), .MEM_SLOTS(NMEM)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic present(input logic [2:0] op, input logic [WW-1:0] w, input logic [NSP-1:0] spf,
                         input logic [NSFU-1:0] sff, input logic [NMEM-1:0] mmf);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_warp = w;
    sp_free = spf; sfu_free = sff; mem_free = mmf;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; membar_clr = '0;
    #1;
  endtask

  task automatic t_reset();
    chk(membar_flags == '0, "R10", 64'(membar_flags), 64'h0);
    idle();
    sp_free = '1; sfu_free = '1; mem_free = '1; #1;
    chk({sp_wr, sfu_wr, mem_wr, issued} == '0, "R6", 64'({sp_wr, sfu_wr, mem_wr, issued}), 64'h0);
  endtask

  task automatic t_alu_sp();
    in_mask = 32'hA5A5_0F0F;
    present(3'd0, 3'd2, 2'b10, 1'b1, 3'b111);
    chk(sp_wr == 2'b10 && sfu_wr == 0, "R2", 64'({sp_wr, sfu_wr}), 64'b100);
    chk(issued && in_ready, "R6", 64'({issued, in_ready}), 64'b11);
    chk(out_warp == 3'd2 && out_mask == 32'hA5A5_0F0F && out_op == 3'd0, "R5",
        64'({out_warp, out_mask}), 64'({3'd2, 32'hA5A5_0F0F}));
    present(3'd7, 3'd1, 2'b11, 1'b1, 3'b000);
    chk(sp_wr == 2'b01, "R5", 64'(sp_wr), 64'b01);
    idle();
  endtask

  task automatic t_alu_fallback();
    present(3'd6, 3'd4, 2'b00, 1'b1, 3'b111);
    chk(sfu_wr == 1'b1 && sp_wr == 0 && mem_wr == 0, "R3", 64'({sp_wr, sfu_wr, mem_wr}), 64'b001000);
    present(3'd0, 3'd4, 2'b00, 1'b0, 3'b111);
    chk(!in_ready && !issued && {sp_wr, sfu_wr, mem_wr} == 0, "R3",
        64'({in_ready, sp_wr, sfu_wr, mem_wr}), 64'h0);
    idle();
  endtask

  task automatic t_sfu();
    present(3'd1, 3'd0, 2'b11, 1'b0, 3'b111);
    chk(!in_ready && sp_wr == 0, "R4", 64'({in_ready, sp_wr}), 64'h0);
    present(3'd1, 3'd0, 2'b11, 1'b1, 3'b111);
    chk(sfu_wr == 1'b1 && sp_wr == 0, "R4", 64'({sp_wr, sfu_wr}), 64'b001);
    idle();
  endtask

  task automatic t_mem();
    present(3'd2, 3'd5, 2'b11, 1'b1, 3'b110);
    chk(mem_wr == 3'b010 && sp_wr == 0 && sfu_wr == 0, "R1", 64'(mem_wr), 64'b010);
    present(3'd3, 3'd5, 2'b11, 1'b1, 3'b000);
    chk(!in_ready && {sp_wr, sfu_wr, mem_wr} == 0, "R1", 64'({in_ready, sp_wr, sfu_wr, mem_wr}), 64'h0);
    @(negedge clk); in_valid = 1'b0; in_op = 3'd2; mem_free = 3'b100; #1;
    chk(in_ready && !issued && mem_wr == 0, "R6", 64'({in_ready, issued, mem_wr}), 64'b1000);
    idle();
  endtask

  task automatic t_barrier();
    present(3'd5, 3'd3, 2'b01, 1'b1, 3'b111);
    chk(bar_arrive && bar_warp == 3'd3 && sp_wr == 2'b01, "R7", 64'({bar_arrive, bar_warp}), 64'b1011);
    present(3'd0, 3'd3, 2'b01, 1'b1, 3'b111);
    chk(!bar_arrive, "R7", 64'(bar_arrive), 64'h0);
    present(3'd5, 3'd3, 2'b00, 1'b0, 3'b111);
    chk(!bar_arrive, "R7", 64'(bar_arrive), 64'h0);
    idle();
  endtask

  task automatic t_membar();
    present(3'd4, 3'd6, 2'b11, 1'b1, 3'b001);
    chk(mem_wr == 3'b001, "R1", 64'(mem_wr), 64'b001);
    idle();
    chk(membar_flags == 8'h40, "R8", 64'(membar_flags), 64'h40);
    present(3'd4, 3'd2, 2'b11, 1'b1, 3'b000);
    idle();
    chk(membar_flags == 8'h40, "R8", 64'(membar_flags), 64'h40);
    present(3'd4, 3'd6, 2'b11, 1'b1, 3'b100);
    membar_clr = 8'h40;
    idle();
    chk(membar_flags == 8'h40, "R8", 64'(membar_flags), 64'h40);
    @(negedge clk); membar_clr = 8'h40; #1;
    idle();
    chk(membar_flags == 8'h00, "R8", 64'(membar_flags), 64'h0);
  endtask

  task automatic t_pc();
    in_pc = 32'h0000_1000; in_size = 4'd8;
    present(3'd0, 3'd1, 2'b01, 1'b1, 3'b111);
    chk(next_pc == 32'h0000_1008 && next_pc_vld, "R9", 64'(next_pc), 64'h1008);
    in_pc = 32'hFFFF_FFFE; in_size = 4'd4; #1;
    chk(next_pc == 32'h0000_0002, "R9", 64'(next_pc), 64'h2);
    present(3'd1, 3'd1, 2'b01, 1'b0, 3'b111);
    chk(!next_pc_vld, "R9", 64'(next_pc_vld), 64'h0);
    idle();
  endtask

  initial begin
    in_valid = 0; in_op = 0; in_warp = 0; in_mask = 0; in_pc = 0; in_size = 0;
    sp_free = 0; sfu_free = 0; mem_free = 0; membar_clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_alu_sp();
    t_alu_fallback();
    t_sfu();
    t_mem();
    t_barrier();
    t_membar();
    t_pc();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule